// File: doc/BRIEF.md
# Programmable Puncturing Serializer

This block sits behind a rate-1/2 convolutional mother encoder. Each accepted input carries the two generator outputs, A and B, for one information bit. The block keeps or drops each of them according to two programmable masks. The masks repeat with a programmable period of k input positions, which gives a k/m code rate. The kept bits leave on a one-bit serial output, at most one per clock cycle.

Every input can produce up to two output bits, so the block buffers pending bits in a short queue. It lowers its ready output when one more input could overflow that queue. Any cycle without an accepted input still lets the queue drain. A period-start strobe marks the first output bit of each puncture period, so a downstream decoder can align to the pattern. A static error output reports a mask setup that cannot produce a valid k/m code.

Top module: `punct_serializer`

## Requirements
- R1: For the input accepted at period position p, the A bit is emitted if and only if bit p of `mask_a` is 1, and the B bit is emitted if and only if bit p of `mask_b` is 1. Position 0 is the first input accepted after reset. The position then advances by one on every accepted input and wraps from k-1 back to 0.
- R2: When both bits of one position are kept, A is emitted before B. Bits of earlier inputs always leave before bits of later inputs.
- R3: `in_ready` is high exactly when the internal queue has at least two free slots, with the default depth of 4. An input offered while `in_ready` is low is ignored: it produces no output bits and does not advance the position.
- R4: `period_start` is high together with the first emitted bit of position 0, which is A if `mask_a[0]` is 1 and otherwise B. It is low on every other cycle.
- R5: `out_valid` is high only on cycles where `out_bit` carries a kept bit, and it is high on every cycle in which the queue holds a pending bit.
- R6: On cycles without an accepted input, one pending bit is emitted per cycle until the queue is empty. `in_ready` is then high.
- R7: `cfg_error` is high when k lies outside 2..12, when the total count of ones in both masks over positions 0..k-1 lies outside k+1..2k-1, or when any position below k has both mask bits at 0. Mask bits at positions k and above have no effect on `cfg_error` or on the output.
- R8: While and just after reset, `out_valid` and `period_start` are low and `in_ready` is high.
- R9: When the queue is empty, the first kept bit of an accepted input appears on the output in the clock cycle that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| k_len | input | 4 | Puncture period k (input positions per period) |
| mask_a | input | 12 | Keep mask for the A channel, bit p for position p |
| mask_b | input | 12 | Keep mask for the B channel, bit p for position p |
| in_valid | input | 1 | Input pair offered this cycle |
| in_a | input | 1 | First generator output of the mother code |
| in_b | input | 1 | Second generator output of the mother code |
| in_ready | output | 1 | Block can accept an input this cycle |
| out_valid | output | 1 | `out_bit` carries a kept bit |
| out_bit | output | 1 | Serial punctured output |
| period_start | output | 1 | First output bit of a puncture period |
| cfg_error | output | 1 | Mask or period setup is invalid |

## Verification
The bench sweeps every mask pair for periods 2 to 4 and compares each one against an arithmetic error rule. A checker that got the wrong bound, or that counted mask bits above k, would flag good setups or pass bad ones. Every valid setup is then run with back-to-back, alternating and two-in-three input patterns while a queue model predicts every output bit and the ready level. A design that swapped the A and B order, placed the period strobe on B when A is kept, or advanced the position on a refused input would drift from that model within one period. Continuous input drives the queue full, so a ready threshold that is off by one shows up either as a lost bit or as a needless stall. Each run ends with idle cycles that must empty the queue.

// File: rtl/punct_pkg.sv
package punct_pkg;
  // one buffered output bit with its period-start marker
  typedef struct packed {
    logic first;
    logic data;
  } pbit_t;
endpackage

// File: rtl/punct_rst_sync.sv
module punct_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/punct_cfg_check.sv
module punct_cfg_check #(
  parameter int MAX_K = 12,
  parameter int KW    = $clog2(MAX_K + 1),
  parameter int CW    = $clog2(2 * MAX_K + 1)
) (
  input  logic [KW-1:0]    k_len,
  input  logic [MAX_K-1:0] mask_a,
  input  logic [MAX_K-1:0] mask_b,
  output logic             cfg_err
);
  logic [CW:0] ones;
  logic [CW:0] lo_lim;
  logic [CW:0] hi_lim;
  logic        hole;
  logic        k_ok;

  always_comb begin
    ones = '0;
    hole = 1'b0;
    for (int p = 0; p < MAX_K; p++) begin
      if (p < int'(k_len)) begin
        ones = ones + (CW + 1)'(mask_a[p]) + (CW + 1)'(mask_b[p]);
        if (!mask_a[p] && !mask_b[p]) hole = 1'b1;
      end
    end
    k_ok    = (int'(k_len) >= 2) && (int'(k_len) <= MAX_K);
    lo_lim  = (CW + 1)'(k_len) + 1'b1;
    hi_lim  = ((CW + 1)'(k_len) << 1) - 1'b1;
    cfg_err = !k_ok || (ones < lo_lim) || (ones > hi_lim) || hole;
  end
endmodule

// File: rtl/punct_pos_ctr.sv
module punct_pos_ctr #(
  parameter int MAX_K = 12,
  parameter int KW    = $clog2(MAX_K + 1),
  parameter int PW    = $clog2(MAX_K)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [KW-1:0] k_len,
  input  logic          cfg_err,
  input  logic          adv,
  output logic [PW-1:0] pos
);
  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_nxt;
  logic          at_last;

  always_comb begin
    at_last = (int'(pos_q) + 1) >= int'(k_len);
    pos_nxt = at_last ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  pos_q <= '0;
    else if (adv) pos_q <= pos_nxt;
  end

  assign pos = pos_q;

  // R1: the position never leaves the programmed period
  assert_pos_in_period_R1: assert property (@(posedge clk) disable iff (!rst_ni || cfg_err)
    int'(pos_q) < int'(k_len));
endmodule

// File: rtl/punct_bit_fifo.sv
module punct_bit_fifo
  import punct_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] push_n,
  input  pbit_t      wr0,
  input  pbit_t      wr1,
  output pbit_t      head,
  output logic       avail,
  output logic       room2
);
  pbit_t           mem_q [DEPTH];
  pbit_t           mem_d [DEPTH];
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;
  logic [CNTW-1:0] cnt_mid;
  logic            upd;

  assign avail = (cnt_q != '0);
  assign room2 = (int'(cnt_q) <= DEPTH - 2);
  assign head  = mem_q[0];
  assign upd   = avail || (push_n != 2'd0);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    cnt_mid = cnt_q;
    if (avail) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i + 1];
      mem_d[DEPTH-1] = '0;
      cnt_mid = cnt_q - 1'b1;
    end
    if (push_n != 2'd0 && int'(cnt_mid) < DEPTH) mem_d[cnt_mid] = wr0;
    if (push_n == 2'd2 && int'(cnt_mid) + 1 < DEPTH) mem_d[cnt_mid + 1'b1] = wr1;
    cnt_d = cnt_mid + CNTW'(push_n);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  // R3: occupancy never exceeds storage
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  // R3: every push request fits after this cycle's pop
  assert_push_fits_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_n != 2'd0) |-> (int'(cnt_q) - int'(avail) + int'(push_n) <= DEPTH));
  // R6: with nothing pushed, a non-empty queue drains by one bit
  assert_drain_one_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (avail && push_n == 2'd0) |=> (int'(cnt_q) == int'($past(cnt_q)) - 1));
endmodule

// File: rtl/punct_serializer.sv
module punct_serializer
  import punct_pkg::*;
#(
  parameter int MAX_K = 12,
  parameter int DEPTH = 4,
  parameter int KW    = $clog2(MAX_K + 1),
  parameter int PW    = $clog2(MAX_K)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KW-1:0]    k_len,
  input  logic [MAX_K-1:0] mask_a,
  input  logic [MAX_K-1:0] mask_b,
  input  logic             in_valid,
  input  logic             in_a,
  input  logic             in_b,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             period_start,
  output logic             cfg_error
);
  logic          rst_int_n;
  logic [PW-1:0] pos;
  logic          accept;
  logic          keep_a;
  logic          keep_b;
  logic [1:0]    push_n;
  pbit_t         wr0;
  pbit_t         wr1;
  pbit_t         head;
  logic          avail;
  logic          room2;

  punct_rst_sync u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  punct_cfg_check #(.MAX_K(MAX_K), .KW(KW)) u_cfg (
    .k_len   (k_len),
    .mask_a  (mask_a),
    .mask_b  (mask_b),
    .cfg_err (cfg_error)
  );

  punct_pos_ctr #(.MAX_K(MAX_K), .KW(KW), .PW(PW)) u_pos (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .k_len   (k_len),
    .cfg_err (cfg_error),
    .adv     (accept),
    .pos     (pos)
  );

  // compaction: A goes first, B follows or takes the first slot alone
  always_comb begin
    accept = in_valid && room2;
    keep_a = mask_a[pos];
    keep_b = mask_b[pos];
    wr0    = '0;
    wr1    = '0;
    push_n = 2'd0;
    if (accept) begin
      push_n = {1'b0, keep_a} + {1'b0, keep_b};
      if (keep_a) begin
        wr0 = '{first: (pos == '0), data: in_a};
        wr1 = '{first: 1'b0,        data: in_b};
      end else begin
        wr0 = '{first: (pos == '0), data: in_b};
      end
    end
  end

  punct_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .push_n (push_n),
    .wr0    (wr0),
    .wr1    (wr1),
    .head   (head),
    .avail  (avail),
    .room2  (room2)
  );

  assign in_ready     = room2;
  assign out_valid    = avail;
  assign out_bit      = head.data;
  assign period_start = avail && head.first;

  // R3: a refused input leaves the period position untouched
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !in_ready) |=> $stable(pos));
  // R4: the period strobe only rides on a valid bit
  assert_start_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    period_start |-> out_valid);
endmodule

// File: tb/punct_serializer_bench.sv
module punct_serializer_bench;
  localparam int MAX_K = 12;
  localparam int KW    = 4;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [KW-1:0]    k_len;
  logic [MAX_K-1:0] ma;
  logic [MAX_K-1:0] mb;
  logic             in_valid;
  logic             in_a;
  logic             in_b;
  logic             in_ready;
  logic             out_valid;
  logic             out_bit;
  logic             period_start;
  logic             cfg_error;

  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;
  logic [1:0] mq[$];   // bit1 = period start, bit0 = data
  int         mpos;

  always #2 clk = ~clk;

  punct_serializer #(.MAX_K(MAX_K), .DEPTH(DEPTH)) u_punct_serializer (
    .clk          (clk),
    .rst_n        (rst_n),
    .k_len        (k_len),
    .mask_a       (ma),
    .mask_b       (mb),
    .in_valid     (in_valid),
    .in_a         (in_a),
    .in_b         (in_b),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_bit      (out_bit),
    .period_start (period_start),
    .cfg_error    (cfg_error)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input int k, input logic [MAX_K-1:0] a, input logic [MAX_K-1:0] b);
    int  ones = 0;
    bit  hole = 1'b0;
    if (k < 2 || k > MAX_K) return 1'b1;
    for (int p = 0; p < k; p++) begin
      ones += int'(a[p]) + int'(b[p]);
      if (!a[p] && !b[p]) hole = 1'b1;
    end
    return (ones < k + 1) || (ones > 2 * k - 1) || hole;
  endfunction

  // one cycle: check outputs against the model, drive, advance the model
  task automatic step(input bit v, input bit a, input bit b);
    int exp_ready;
    exp_ready = (mq.size() <= DEPTH - 2) ? 1 : 0;
    chk("R3", "in_ready", int'(in_ready), exp_ready);
    if (mq.size() > 0) begin
      chk("R5", "out_valid", int'(out_valid), 1);
      chk("R1/R2", "out_bit", int'(out_bit), int'(mq[0][0]));
      chk("R4", "period_start", int'(period_start), int'(mq[0][1]));
    end else begin
      chk("R5", "out_valid idle", int'(out_valid), 0);
      chk("R4", "period_start idle", int'(period_start), 0);
    end
    in_valid = v;
    in_a     = a;
    in_b     = b;
    if (mq.size() > 0) void'(mq.pop_front());
    if (v && exp_ready == 1) begin
      if (ma[mpos]) mq.push_back({mpos == 0, a});
      if (mb[mpos]) mq.push_back({(mpos == 0) && !ma[mpos], b});
      mpos = (mpos == int'(k_len) - 1) ? 0 : mpos + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_a     = 1'b0;
    in_b     = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mq.delete();
    mpos = 0;
    chk("R8", "out_valid after reset", int'(out_valid), 0);
    chk("R8", "period_start after reset", int'(period_start), 0);
    chk("R8", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic run_cfg(input int k, input logic [MAX_K-1:0] a, input logic [MAX_K-1:0] b, input int mode);
    logic [7:0] h;
    bit         v;
    k_len = KW'(k);
    ma    = a;
    mb    = b;
    do_reset();
    for (int i = 0; i < 4 * k + 3; i++) begin
      v = (mode == 0) ? 1'b1 : (mode == 1) ? (i % 2 == 0) : (i % 3 != 2);
      h = 8'(i * 29 + int'(a[7:0]) * 7 + int'(b[7:0]) * 3 + k);
      step(v, h[3], h[6]);
      if (i == 0) chk("R9", "first bit next cycle", int'(out_valid), 1);
    end
    repeat (2 * DEPTH + 2) step(1'b0, 1'b0, 1'b0);
    chk("R6", "drained out_valid", int'(out_valid), 0);
    chk("R6", "drained in_ready", int'(in_ready), 1);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = 1'b0;
    in_b     = 1'b0;
    k_len    = KW'(2);
    ma       = '0;
    mb       = '0;
    mpos     = 0;

    // exhaustive mask sweep for short periods
    for (int k = 2; k <= 4; k++) begin
      for (int a = 0; a < (1 << k); a++) begin
        for (int b = 0; b < (1 << k); b++) begin
          bit e;
          k_len = KW'(k);
          ma    = MAX_K'(a);
          mb    = MAX_K'(b);
          #1;
          e = exp_err(k, MAX_K'(a), MAX_K'(b));
          chk("R7", "cfg_error sweep", int'(cfg_error), int'(e));
          if (!e) run_cfg(k, MAX_K'(a), MAX_K'(b), (a + b) % 3);
        end
      end
    end

    // rate 2/3 setting: A kept at both positions, B kept at position 0 only
    run_cfg(2, 12'b11, 12'b01, 0);

    // mask bits above the period must not matter
    k_len = KW'(2);
    ma    = 12'hF03;
    mb    = 12'h0F1;
    #1;
    chk("R7", "cfg_error upper bits", int'(cfg_error), 0);
    run_cfg(2, 12'hF03, 12'h0F1, 0);

    // period out of range
    k_len = KW'(1); ma = 12'h001; mb = 12'h001; #1;
    chk("R7", "cfg_error k=1", int'(cfg_error), 1);
    k_len = KW'(13); ma = 12'hFFF; mb = 12'h0FF; #1;
    chk("R7", "cfg_error k=13", int'(cfg_error), 1);
    k_len = KW'(0); ma = 12'h003; mb = 12'h001; #1;
    chk("R7", "cfg_error k=0", int'(cfg_error), 1);

    // longest period, ones count 16 of allowed 13..23
    k_len = KW'(12); ma = 12'hFFF; mb = 12'h0A5; #1;
    chk("R7", "cfg_error k=12", int'(cfg_error), 0);
    for (int m = 0; m < 3; m++) run_cfg(12, 12'hFFF, 12'h0A5, m);
    // longest period with a hole at position 11
    k_len = KW'(12); ma = 12'h7FF; mb = 12'h0A5; #1;
    chk("R7", "cfg_error k=12 hole", int'(cfg_error), 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule